// File: doc/BRIEF.md
# Framebuffer CPU Access Arbiter

This block shares one 16-bit framebuffer memory between the display scanout engine and an 8-bit CPU bus. Scanout always wins: while the `scan_busy` input is high the arbiter leaves the memory port alone. CPU writes do not stall. They go into a small queue and drain into memory in arrival order whenever scanout goes idle, for example during blanking. CPU reads cannot be deferred, so a read that cannot be served yet holds the CPU with `cpu_wait` until the memory is free.

Each CPU write carries a bit mask and a fill flag. A full mask gives a single write cycle into one byte lane. A partial mask turns the entry into a read-modify-write pair, which costs an extra memory cycle. Fill mode puts the same byte into both halves of the word, so two pixels change in one cycle. A read whose word matches a queued write waits until the queue has drained that write, so the CPU never sees stale pixels.

Top module: `fb_arbiter`

## Requirements
- R1: The memory port (`mem_en`) is never asserted in a cycle where `scan_busy` is high.
- R2: A CPU read issues one memory read cycle and holds `cpu_wait` high until the data is ready. With the port free and nothing queued for that word, `cpu_wait` drops exactly two cycles after the request appears. While `scan_busy` stays high, the read keeps waiting.
- R3: A CPU write is accepted without wait states while the queue has room. With 8 entries pending, a further write waits until an entry drains.
- R4: Queued writes reach memory only while `scan_busy` is low, and in the order they were accepted.
- R5: Byte address bit 0 selects the lane. 0 writes the low byte (`mem_be`=01, data on bits 7:0). 1 writes the high byte (`mem_be`=10, data on bits 15:8). `mem_addr` is the byte address shifted right by one.
- R6: With `cpu_fill` high, the data byte is written to both lanes (`mem_be`=11), whatever the value of address bit 0.
- R7: Mask bit value 1 takes the new data bit and 0 keeps the stored bit. A mask of FF costs one write cycle. Any other mask costs a read cycle followed by a write cycle of the merged word.
- R8: A CPU read of a word that has a write pending in the queue waits until that write has reached memory, and returns the new data.
- R9: Once the read half of a read-modify-write has started, a rise of `scan_busy` defers the write half until `scan_busy` falls. The merged result is still correct.
- R10: After reset the queue is empty, `cpu_wait` is low with no request, and the memory port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_busy | input | 1 | Scanout owns the memory this cycle |
| cpu_sel | input | 1 | CPU request, held until `cpu_wait` is low at a clock edge |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 8 | Write data byte |
| cpu_mask | input | 8 | Per-bit write mask, 1 = update bit |
| cpu_fill | input | 1 | Write the byte into both lanes |
| cpu_rdata | output | 8 | Read data, valid while `cpu_wait` is low on a read |
| cpu_wait | output | 1 | Wait state for the current CPU request |
| mem_en | output | 1 | Memory cycle this clock |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_be | output | 2 | Byte-lane enables for write cycles |
| mem_wdata | output | 16 | Write data word |
| mem_rdata | input | 16 | Read data, registered one cycle after a read cycle |

## Verification
A CPU read and a queue drain can both want the free memory port in the same cycle. When they hit the same word, serving the read first would return stale data. The bench provokes this by queueing a write while scanout is busy, posting a read to the same byte, and only then releasing `scan_busy`. The returned byte must be the queued value. A second collision is scanout reclaiming the memory between the two halves of a read-modify-write. The bench raises `scan_busy` right after the read half is seen, counts any memory write while busy, and checks the merged byte once the port is released.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_WAIT,
      ST_RD_DONE,
      ST_MW_WAIT,
      ST_MW_WR
   } arb_state_t;

   localparam logic [7:0] FULL_MASK = 8'hFF;

endpackage

// File: rtl/fb_wq.sv
module fb_wq #(
   parameter int WORD_W = 15,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              push_hi,
   input  logic [7:0]        push_data,
   input  logic [7:0]        push_mask,
   input  logic              push_fill,
   input  logic              pop,
   output logic [WORD_W-1:0] head_word,
   output logic              head_hi,
   output logic [7:0]        head_data,
   output logic [7:0]        head_mask,
   output logic              head_fill,
   output logic              empty,
   output logic              full,
   input  logic [WORD_W-1:0] look_word,
   output logic              hit
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WORD_W-1:0] word_m [DEPTH];
   logic              hi_m   [DEPTH];
   logic [7:0]        data_m [DEPTH];
   logic [7:0]        mask_m [DEPTH];
   logic              fill_m [DEPTH];
   logic [DEPTH-1:0]  valid_q, valid_d, match;
   logic [PTR_W-1:0]  wp_q, rp_q;

   assign empty = ~|valid_q;
   assign full  = &valid_q;

   always_comb begin
      valid_d = valid_q;
      if (pop)  valid_d[rp_q] = 1'b0;
      if (push) valid_d[wp_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         wp_q    <= '0;
         rp_q    <= '0;
      end else begin
         valid_q <= valid_d;
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         word_m[wp_q] <= push_word;
         hi_m[wp_q]   <= push_hi;
         data_m[wp_q] <= push_data;
         mask_m[wp_q] <= push_mask;
         fill_m[wp_q] <= push_fill;
      end
   end

   assign head_word = word_m[rp_q];
   assign head_hi   = hi_m[rp_q];
   assign head_data = data_m[rp_q];
   assign head_mask = mask_m[rp_q];
   assign head_fill = fill_m[rp_q];

   // one comparator per slot; a read hazard exists if any live slot targets the word
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign match[g] = valid_q[g] && (word_m[g] == look_word);
   end
   assign hit = |match;

endmodule

// File: rtl/fb_merge.sv
module fb_merge (
   input  logic [15:0] old_word,
   input  logic [7:0]  data,
   input  logic [7:0]  mask,
   input  logic        hi,
   input  logic        fill,
   output logic [15:0] new_word,
   output logic [1:0]  lane_be
);
   logic [15:0] lane_mask;

   always_comb begin
      if (fill) begin
         lane_mask = {mask, mask};
         lane_be   = 2'b11;
      end else if (hi) begin
         lane_mask = {mask, 8'h00};
         lane_be   = 2'b10;
      end else begin
         lane_mask = {8'h00, mask};
         lane_be   = 2'b01;
      end
      new_word = (old_word & ~lane_mask) | ({data, data} & lane_mask);
   end
endmodule

// File: rtl/fb_arbiter.sv
module fb_arbiter
   import fb_arb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_busy,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic [7:0]        cpu_mask,
   input  logic              cpu_fill,
   output logic [7:0]        cpu_rdata,
   output logic              cpu_wait,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-2:0] mem_addr,
   output logic [1:0]        mem_be,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata
);
   localparam int WORD_W = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("fb_arbiter: ADDR_W must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fb_arbiter: DEPTH must be a power of two, at least 2");
   end

   arb_state_t        state_q, state_d;
   logic [15:0]       hold_q;
   logic              cap;
   logic              rd_req, wr_req;
   logic              q_push, q_pop, q_empty, q_full, q_hit;
   logic [WORD_W-1:0] head_word;
   logic              head_hi, head_fill;
   logic [7:0]        head_data, head_mask;
   logic [15:0]       mrg_word;
   logic [1:0]        mrg_be;
   logic              needs_rmw;

   assign rd_req = cpu_sel && !cpu_wr;
   assign wr_req = cpu_sel && cpu_wr;
   assign q_push = wr_req && !q_full;

   fb_wq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_word (cpu_addr[ADDR_W-1:1]),
      .push_hi   (cpu_addr[0]),
      .push_data (cpu_wdata),
      .push_mask (cpu_mask),
      .push_fill (cpu_fill),
      .pop       (q_pop),
      .head_word (head_word),
      .head_hi   (head_hi),
      .head_data (head_data),
      .head_mask (head_mask),
      .head_fill (head_fill),
      .empty     (q_empty),
      .full      (q_full),
      .look_word (cpu_addr[ADDR_W-1:1]),
      .hit       (q_hit)
   );

   fb_merge u_merge (
      .old_word (hold_q),
      .data     (head_data),
      .mask     (head_mask),
      .hi       (head_hi),
      .fill     (head_fill),
      .new_word (mrg_word),
      .lane_be  (mrg_be)
   );

   assign needs_rmw = (head_mask != FULL_MASK);
   assign mem_wdata = mrg_word;

   always_comb begin
      state_d  = state_q;
      mem_en   = 1'b0;
      mem_we   = 1'b0;
      mem_addr = head_word;
      mem_be   = 2'b00;
      q_pop    = 1'b0;
      cap      = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!scan_busy) begin
               if (rd_req && !q_hit) begin
                  mem_en   = 1'b1;
                  mem_addr = cpu_addr[ADDR_W-1:1];
                  mem_be   = 2'b11;
                  state_d  = ST_RD_WAIT;
               end else if (!q_empty) begin
                  mem_en = 1'b1;
                  if (needs_rmw) begin
                     mem_be  = 2'b11;
                     state_d = ST_MW_WAIT;
                  end else begin
                     mem_we = 1'b1;
                     mem_be = mrg_be;
                     q_pop  = 1'b1;
                  end
               end
            end
         end
         ST_RD_WAIT: begin
            cap     = 1'b1;
            state_d = ST_RD_DONE;
         end
         ST_RD_DONE: state_d = ST_IDLE;
         ST_MW_WAIT: begin
            cap     = 1'b1;
            state_d = ST_MW_WR;
         end
         ST_MW_WR: begin
            if (!scan_busy) begin
               mem_en  = 1'b1;
               mem_we  = 1'b1;
               mem_be  = mrg_be;
               q_pop   = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         if (cap) hold_q <= mem_rdata;
      end
   end

   assign cpu_wait  = rd_req ? (state_q != ST_RD_DONE) : (wr_req && q_full);
   assign cpu_rdata = cpu_addr[0] ? hold_q[15:8] : hold_q[7:0];

endmodule

// File: rtl/fb_arbiter_chk.sv
module fb_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scan_busy,
   input logic       cpu_sel,
   input logic       cpu_wr,
   input logic       cpu_wait,
   input logic       mem_en,
   input logic       mem_we,
   input logic [1:0] mem_be,
   input logic       q_full,
   input logic       q_empty
);
   // R1
   a_r1_port_free_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !scan_busy);

   // R2: a served read was issued to memory two cycles earlier
   a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && !cpu_wr && !cpu_wait) |-> $past(mem_en && !mem_we, 2));

   // R3
   a_r3_write_wait_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && cpu_wr && cpu_wait) |-> q_full);

   // R4: a write cycle always drains a queued entry
   a_r4_write_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> !q_empty);

   // R5 / R6: write cycles enable at least one lane
   a_r5_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_be != 2'b00));
endmodule

bind fb_arbiter fb_arbiter_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_busy (scan_busy),
   .cpu_sel   (cpu_sel),
   .cpu_wr    (cpu_wr),
   .cpu_wait  (cpu_wait),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_be    (mem_be),
   .q_full    (q_full),
   .q_empty   (q_empty)
);

// File: tb/sim_fb_arbiter.sv
`timescale 1ns/1ps
module sim_fb_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_busy = 1'b0;
   logic        cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_fill = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, cpu_mask = 8'hFF;
   logic [7:0]  cpu_rdata;
   logic        cpu_wait, mem_en, mem_we;
   logic [14:0] mem_addr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int checks = 0, errors = 0;
   int busy_viol = 0, wr_cnt = 0, rd_cnt = 0, log_n = 0;
   logic [15:0] mem [256];
   logic [14:0] log_addr [16];
   logic [1:0]  log_be [16];

   always #10 clk = ~clk;

   fb_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .scan_busy(scan_busy),
      .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_mask(cpu_mask), .cpu_fill(cpu_fill),
      .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // memory model: registered read, lane-masked write
   always @(posedge clk) begin
      if (mem_en) begin
         if (scan_busy) busy_viol <= busy_viol + 1;
         if (mem_we) begin
            if (mem_be[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
            wr_cnt <= wr_cnt + 1;
            if (log_n < 16) begin
               log_addr[log_n] <= mem_addr;
               log_be[log_n]   <= mem_be;
               log_n <= log_n + 1;
            end
         end else begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] m,
                            input logic f, output int waits);
      waits = 0;
      cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_mask = m; cpu_fill = f;
      @(negedge clk);
      while (cpu_wait) begin waits++; @(negedge clk); end
      @(posedge clk); #1;
      cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_fill = 1'b0; cpu_mask = 8'hFF;
   endtask

   task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output int waits);
      waits = 0;
      cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
      @(negedge clk);
      while (cpu_wait) begin waits++; @(negedge clk); end
      d = cpu_rdata;
      @(posedge clk); #1;
      cpu_sel = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   typedef struct packed {
      logic [15:0] a;
      logic [7:0]  d;
      logic [7:0]  m;
      logic        f;
      logic [7:0]  e;   // byte expected at a after all vectors drain
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{16'h0010, 8'h3C, 8'hFF, 1'b0, 8'h3F},
      '{16'h0013, 8'hC3, 8'hFF, 1'b0, 8'h03},
      '{16'h0014, 8'h77, 8'hFF, 1'b1, 8'h77},
      '{16'h0010, 8'hFF, 8'h0F, 1'b0, 8'h3F},
      '{16'h0011, 8'h5A, 8'hFF, 1'b0, 8'h5A},
      '{16'h0013, 8'h0F, 8'hF0, 1'b0, 8'h03}
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int w;
      logic [7:0] d;
      int wr0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk("R10 wait low in reset", cpu_wait, 0);
      chk("R10 port idle in reset", mem_en, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R10 port idle after reset", mem_en, 0);

      // vector table: queue under scanout, then drain in blanking
      scan_busy = 1'b1;
      for (int i = 0; i < 6; i++) begin
         cpu_write(VECS[i].a, VECS[i].d, VECS[i].m, VECS[i].f, w);
         chk("R3 buffered write no wait", w, 0);
      end
      repeat (5) @(posedge clk); #1;
      chk("R4 nothing written while busy", wr_cnt, 0);
      rd_cnt = 0;
      scan_busy = 1'b0;
      repeat (30) @(posedge clk); #1;
      chk("R7 six write cycles", wr_cnt, 6);
      chk("R7 two rmw reads", rd_cnt, 2);
      for (int i = 0; i < 6; i++) begin
         cpu_read(VECS[i].a, d, w);
         chk("R7 vector readback", d, VECS[i].e);
         chk("R2 idle read latency", w, 2);
      end
      cpu_read(16'h0015, d, w);
      chk("R6 fill reaches high lane", d, 8'h77);

      // R3/R4/R5: fill the queue, one more write waits; order and lanes
      scan_busy = 1'b1;
      log_n = 0;
      for (int i = 0; i < 8; i++) begin
         cpu_write(16'h0040 + 16'(i), 8'h10 + 8'(i), 8'hFF, 1'b0, w);
         chk("R3 write while room", w, 0);
      end
      fork
         cpu_write(16'h0048, 8'h18, 8'hFF, 1'b0, w);
         begin repeat (6) @(posedge clk); #1; scan_busy = 1'b0; end
      join
      chk("R3 write waits when full", (w >= 6) ? 1 : 0, 1);
      repeat (20) @(posedge clk); #1;
      chk("R4 drained count", log_n, 9);
      for (int i = 0; i < 9; i++) begin
         chk("R4 arrival order", log_addr[i], 15'h20 + 15'(i / 2));
         chk("R5 lane from bit0", log_be[i], (i % 2 == 0) ? 2'b01 : 2'b10);
      end
      cpu_read(16'h0047, d, w);
      chk("R5 high lane data", d, 8'h17);

      // R2: read during scanout waits
      scan_busy = 1'b1;
      fork
         cpu_read(16'h0010, d, w);
         begin repeat (5) @(posedge clk); #1; scan_busy = 1'b0; end
      join
      chk("R2 read held during scan", (w >= 5) ? 1 : 0, 1);
      chk("R2 read data", d, 8'h3F);

      // R8: read hits a queued write
      scan_busy = 1'b1;
      cpu_write(16'h0030, 8'h99, 8'hFF, 1'b0, w);
      fork
         cpu_read(16'h0030, d, w);
         begin repeat (4) @(posedge clk); #1; scan_busy = 1'b0; end
      join
      chk("R8 read returns queued data", d, 8'h99);

      // R9: scanout takes the port between rmw halves
      cpu_write(16'h0050, 8'hAA, 8'hFF, 1'b0, w);
      repeat (4) @(posedge clk); #1;
      cpu_write(16'h0050, 8'h55, 8'h3C, 1'b0, w);
      @(negedge clk);
      chk("R9 rmw read half issued", (mem_en && !mem_we) ? 1 : 0, 1);
      @(posedge clk); #1;
      scan_busy = 1'b1;
      wr0 = wr_cnt;
      repeat (6) @(posedge clk); #1;
      chk("R9 write half deferred", wr_cnt - wr0, 0);
      scan_busy = 1'b0;
      repeat (4) @(posedge clk); #1;
      chk("R9 write half done", wr_cnt - wr0, 1);
      cpu_read(16'h0050, d, w);
      chk("R9 merged byte", d, 8'h96);
      cpu_read(16'h0051, d, w);
      chk("R9 other lane kept", d, 8'h00);

      chk("R1 no port use during scan", busy_viol, 0);
      finish_run();
   end
endmodule